// File: doc/BRIEF.md
# Cached-CPU Peripheral Bridge with IDE PIO-0 Timing

This bridge sits between a 32-bit CPU bus, whose data cache would otherwise capture peripheral reads, and two slow peripherals: a UART and the two register blocks of an IDE/ATA task file in PIO mode 0. Each address is mapped to one of four windows: UART, IDE command block, IDE control block, or none. The CPU's cache-inhibit input is driven combinationally from that decode. Any access that lands in a peripheral window is marked uncacheable in the same cycle its address appears. A tight loop that reads the 16-bit IDE data port therefore gets a new word every time, rather than the first word returned again from the cache.

IDE accesses are timed in hardware by a small sequencer. It raises the chip select, waits an address-setup interval, drives the read or write strobe for a fixed width, holds the chip select for one more cycle and then acknowledges. A recovery counter starts when each strobe ends. A request that arrives while it is still running is held back until it expires. The recovery stretch is sized so that strobe-to-strobe spacing meets the PIO-0 cycle time at 25 MHz, whatever the software loop does. The UART is acknowledged after one clock. An address that hits no window receives a bus error after a fixed timeout.

The CPU keeps `cpu_as` high with a stable address and direction until it sees an acknowledge or a bus error. It then drops `cpu_as` for at least one clock edge.

Top module: `periph_bridge`

## Requirements
- R1: While reset is held and right after its release, every chip select and strobe is inactive (high), and `cpu_ack`, `cpu_berr` and `cpu_ci` are low when `cpu_as` is low.
- R2: `cpu_ci` is high in the same cycle `cpu_as` is high with an address in the UART window or either IDE window. It is low when `cpu_as` is low or the address is unmapped.
- R3: Window map, on 256-byte windows. UART is 0xFFF0_0000, with byte offsets 0..7 valid and `uart_reg` = addr[2:0]. IDE command block is 0xFFF0_0100 and uses `ide_cs0_n`. IDE control block is 0xFFF0_0200 and uses `ide_cs1_n`. For both IDE windows `ide_da` = addr[3:1], and the offset must be even and below 16. Any other address is unmapped.
- R4: On an IDE access the selected chip select goes low exactly 2 clocks before the strobe goes low.
- R5: The IDE strobe is low for exactly 5 clocks. `ide_rd_n` is used when `cpu_rw`=1 (read) and `ide_wr_n` when `cpu_rw`=0. The two are never low together.
- R6: From an idle bridge with recovery expired, an IDE access is acknowledged by a one-cycle `cpu_ack` 8 clocks after the request is first sampled. This falls in the cycle after the strobe ends, with the chip select still low.
- R7: The high time between two IDE strobes is at least 7 clocks. A request that is already waiting starts its strobe exactly 15 clocks after the previous strobe started.
- R8: An IDE request that arrives during recovery is not acknowledged until recovery completes, so its latency exceeds 8 clocks.
- R9: A UART access drives `uart_cs_n` low while `cpu_as` is high, and gets a one-cycle `cpu_ack` 1 clock after it is first sampled. No IDE signal moves.
- R10: An unmapped access produces no chip select and no `cpu_ack`, and gets a one-cycle `cpu_berr` 32 clocks after it is first sampled.
- R11: Each access gets exactly one response. While `cpu_as` stays high after the ack or bus error, no further strobe, ack or bus error occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_as | input | 1 | Access request; address and direction valid |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 32 | Byte address |
| cpu_ci | output | 1 | Cache-inhibit to the CPU |
| cpu_ack | output | 1 | One-cycle transfer acknowledge |
| cpu_berr | output | 1 | One-cycle bus error for unmapped access |
| uart_cs_n | output | 1 | UART chip select, active low |
| uart_reg | output | 3 | UART register offset |
| ide_cs0_n | output | 1 | IDE command-block select, active low |
| ide_cs1_n | output | 1 | IDE control-block select, active low |
| ide_da | output | 3 | IDE register address |
| ide_rd_n | output | 1 | IDE read strobe, active low |
| ide_wr_n | output | 1 | IDE write strobe, active low |

## Verification
The interesting overlap is a new IDE request arriving in the same cycle as the recovery counter is still counting down from the previous strobe. The sequencer must then neither start setup nor acknowledge. The bench provokes this by issuing a second data-port read only a few clocks after the first ack. It judges the outcome at the pins: the second strobe must start exactly 15 clocks after the first, the high gap must be at least the recovery time, and the ack latency must exceed the idle-bridge latency. Cache-inhibit is checked in the very cycle each request appears, so that it is known to come before any strobe or ack.

// File: rtl/pb_pkg.sv
package pb_pkg;

  localparam int PB_AW = 32;

  typedef enum logic [1:0] {
    RG_NONE,
    RG_UART,
    RG_CMD,
    RG_CTL
  } region_e;

  typedef enum logic [2:0] {
    IT_IDLE,
    IT_SETUP,
    IT_STROBE,
    IT_HOLD,
    IT_DONE
  } ide_st_e;

  // Two addresses fall in the same window when they agree above bit lsb.
  function automatic logic win_hit(input logic [PB_AW-1:0] a,
                                   input logic [PB_AW-1:0] base,
                                   input int lsb);
    return (a >> lsb) == (base >> lsb);
  endfunction

  // Clocks from one strobe start to the next when a request is waiting.
  function automatic int strobe_spacing(input int setup, input int strobe,
                                        input int recovery);
    return setup + strobe + recovery + 1;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Counter width able to hold the value m.
  function automatic int cnt_bits(input int m);
    return (m < 1) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/pb_decode.sv
module pb_decode
  import pb_pkg::*;
#(
  parameter logic [PB_AW-1:0] UART_BASE  = 32'hFFF0_0000,
  parameter logic [PB_AW-1:0] CMD_BASE   = 32'hFFF0_0100,
  parameter logic [PB_AW-1:0] CTL_BASE   = 32'hFFF0_0200,
  parameter int               REGION_LSB = 8,
  parameter int               UART_OFS_W = 3
) (
  input  logic                  as_i,
  input  logic [PB_AW-1:0]      addr_i,
  output region_e               region_o,
  output logic                  ci_o,
  output logic [2:0]            da_o,
  output logic [UART_OFS_W-1:0] uofs_o
);

  // IDE registers are 16-bit, so da comes from bits [3:1]; bits above must be 0.
  localparam int IDE_HI = 4;

  logic ide_ofs_ok;
  logic uart_ofs_ok;

  assign ide_ofs_ok  = (addr_i[REGION_LSB-1:IDE_HI] == '0) && !addr_i[0];
  assign uart_ofs_ok = (addr_i[REGION_LSB-1:UART_OFS_W] == '0);

  always_comb begin
    region_o = RG_NONE;
    if (win_hit(addr_i, UART_BASE, REGION_LSB) && uart_ofs_ok)
      region_o = RG_UART;
    else if (win_hit(addr_i, CMD_BASE, REGION_LSB) && ide_ofs_ok)
      region_o = RG_CMD;
    else if (win_hit(addr_i, CTL_BASE, REGION_LSB) && ide_ofs_ok)
      region_o = RG_CTL;
  end

  // Cache-inhibit straight from decode: valid in the cycle the address appears.
  assign ci_o   = as_i && (region_o != RG_NONE);
  assign da_o   = addr_i[IDE_HI-1:1];
  assign uofs_o = addr_i[UART_OFS_W-1:0];

endmodule

// File: rtl/pb_ide_timer.sv
module pb_ide_timer
  import pb_pkg::*;
#(
  parameter int SETUP_CLKS    = 2,
  parameter int STROBE_CLKS   = 5,
  parameter int HOLD_CLKS     = 1,
  parameter int RECOVERY_CLKS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       as_i,
  input  logic       ctl_i,
  input  logic       rd_i,
  input  logic [2:0] da_i,
  output logic       cs0_n_o,
  output logic       cs1_n_o,
  output logic [2:0] da_o,
  output logic       rd_n_o,
  output logic       wr_n_o,
  output logic       ack_o
);

  localparam int PH_MAX = max3(SETUP_CLKS, STROBE_CLKS, HOLD_CLKS);
  localparam int PH_W   = cnt_bits(PH_MAX);
  localparam int REC_W  = cnt_bits(RECOVERY_CLKS);

  ide_st_e          st;
  logic [PH_W-1:0]  ph;
  logic [REC_W-1:0] rec;
  logic             sel_ctl_q;
  logic             rd_q;
  logic [2:0]       da_q;

  // Named internal events.
  logic ph_last;
  logic strobe_end;
  logic rec_idle;
  logic launch;
  logic cs_on;

  assign ph_last    = (ph == '0);
  assign strobe_end = (st == IT_STROBE) && ph_last;
  assign rec_idle   = (rec == '0);
  assign launch     = (st == IT_IDLE) && req_i && rec_idle;
  assign cs_on      = (st == IT_SETUP) || (st == IT_STROBE) || (st == IT_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IT_IDLE;
      ph        <= '0;
      rec       <= '0;
      sel_ctl_q <= 1'b0;
      rd_q      <= 1'b1;
      da_q      <= '0;
    end else begin
      if (strobe_end)
        rec <= REC_W'(RECOVERY_CLKS);
      else if (!rec_idle)
        rec <= rec - REC_W'(1);

      case (st)
        IT_IDLE: begin
          if (launch) begin
            st        <= IT_SETUP;
            ph        <= PH_W'(SETUP_CLKS - 1);
            sel_ctl_q <= ctl_i;
            rd_q      <= rd_i;
            da_q      <= da_i;
          end
        end
        IT_SETUP: begin
          if (ph_last) begin
            st <= IT_STROBE;
            ph <= PH_W'(STROBE_CLKS - 1);
          end else begin
            ph <= ph - PH_W'(1);
          end
        end
        IT_STROBE: begin
          if (ph_last) begin
            st <= IT_HOLD;
            ph <= PH_W'(HOLD_CLKS - 1);
          end else begin
            ph <= ph - PH_W'(1);
          end
        end
        IT_HOLD: begin
          if (ph_last) st <= IT_DONE;
          else         ph <= ph - PH_W'(1);
        end
        IT_DONE: begin
          if (!as_i) st <= IT_IDLE;
        end
        default: st <= IT_IDLE;
      endcase
    end
  end

  assign cs0_n_o = !(cs_on && !sel_ctl_q);
  assign cs1_n_o = !(cs_on && sel_ctl_q);
  assign da_o    = da_q;
  assign rd_n_o  = !((st == IT_STROBE) && rd_q);
  assign wr_n_o  = !((st == IT_STROBE) && !rd_q);
  assign ack_o   = (st == IT_HOLD) && ph_last;

  // R5: read and write strobes are never low together.
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  // R4: a strobe only begins under a chip select already active a cycle earlier.
  a_r4_cs_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n_o & wr_n_o) |-> $past(!(cs0_n_o & cs1_n_o)));

  // R7: a strobe never begins while recovery is still counting.
  a_r7_strobe_after_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n_o & wr_n_o) |-> rec_idle);

  // R6: the acknowledge falls after the strobe, with the select still held.
  a_r6_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (rd_n_o && wr_n_o && !(cs0_n_o && cs1_n_o)));

endmodule

// File: rtl/pb_timeout.sv
module pb_timeout
  import pb_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  output logic berr_o
);

  localparam int CW = cnt_bits(TIMEOUT_CLKS + 1);

  logic [CW-1:0] cnt;
  logic          spent;

  // After the error the count parks one past the limit until the request drops.
  assign spent = (cnt == CW'(TIMEOUT_CLKS + 1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!pend_i) cnt <= '0;
    else if (!spent)  cnt <= cnt + CW'(1);
  end

  assign berr_o = (cnt == CW'(TIMEOUT_CLKS));

  // R10: bus error is a single-cycle pulse.
  a_r10_berr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |=> !berr_o);

  // R10: bus error only for a request still pending.
  a_r10_berr_pending: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |-> pend_i);

endmodule

// File: rtl/periph_bridge.sv
module periph_bridge
  import pb_pkg::*;
#(
  parameter logic [31:0] UART_BASE     = 32'hFFF0_0000,
  parameter logic [31:0] CMD_BASE      = 32'hFFF0_0100,
  parameter logic [31:0] CTL_BASE      = 32'hFFF0_0200,
  parameter int          REGION_LSB    = 8,
  parameter int          SETUP_CLKS    = 2,
  parameter int          STROBE_CLKS   = 5,
  parameter int          HOLD_CLKS     = 1,
  parameter int          RECOVERY_CLKS = 7,
  parameter int          TIMEOUT_CLKS  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_as,
  input  logic        cpu_rw,
  input  logic [31:0] cpu_addr,
  output logic        cpu_ci,
  output logic        cpu_ack,
  output logic        cpu_berr,
  output logic        uart_cs_n,
  output logic [2:0]  uart_reg,
  output logic        ide_cs0_n,
  output logic        ide_cs1_n,
  output logic [2:0]  ide_da,
  output logic        ide_rd_n,
  output logic        ide_wr_n
);

  localparam int UART_OFS_W = 3;
  localparam int CYCLE_CLKS = strobe_spacing(SETUP_CLKS, STROBE_CLKS, RECOVERY_CLKS);

  region_e    region;
  logic [2:0] da_dec;
  logic       ide_req;
  logic       ide_ack;
  logic       ua_hit;
  logic       ua_ack_q;
  logic       ua_done_q;
  logic       miss_pend;

  pb_decode #(
    .UART_BASE (UART_BASE),
    .CMD_BASE  (CMD_BASE),
    .CTL_BASE  (CTL_BASE),
    .REGION_LSB(REGION_LSB),
    .UART_OFS_W(UART_OFS_W)
  ) u_dec (
    .as_i    (cpu_as),
    .addr_i  (cpu_addr),
    .region_o(region),
    .ci_o    (cpu_ci),
    .da_o    (da_dec),
    .uofs_o  (uart_reg)
  );

  assign ide_req = cpu_as && ((region == RG_CMD) || (region == RG_CTL));

  pb_ide_timer #(
    .SETUP_CLKS   (SETUP_CLKS),
    .STROBE_CLKS  (STROBE_CLKS),
    .HOLD_CLKS    (HOLD_CLKS),
    .RECOVERY_CLKS(RECOVERY_CLKS)
  ) u_ide (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (ide_req),
    .as_i   (cpu_as),
    .ctl_i  (region == RG_CTL),
    .rd_i   (cpu_rw),
    .da_i   (da_dec),
    .cs0_n_o(ide_cs0_n),
    .cs1_n_o(ide_cs1_n),
    .da_o   (ide_da),
    .rd_n_o (ide_rd_n),
    .wr_n_o (ide_wr_n),
    .ack_o  (ide_ack)
  );

  assign miss_pend = cpu_as && (region == RG_NONE);

  pb_timeout #(
    .TIMEOUT_CLKS(TIMEOUT_CLKS)
  ) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .pend_i(miss_pend),
    .berr_o(cpu_berr)
  );

  // UART: one-clock acknowledge, then quiet until the request drops.
  assign ua_hit    = cpu_as && (region == RG_UART);
  assign uart_cs_n = !ua_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ua_ack_q  <= 1'b0;
      ua_done_q <= 1'b0;
    end else begin
      ua_ack_q  <= ua_hit && !ua_ack_q && !ua_done_q;
      ua_done_q <= ua_hit && (ua_ack_q || ua_done_q);
    end
  end

  assign cpu_ack = ide_ack || ua_ack_q;

  // R2: whenever an IDE select is active the CPU sees cache-inhibit.
  a_r2_ci_covers_ide: assert property (@(posedge clk) disable iff (!rst_n)
    !(ide_cs0_n && ide_cs1_n) |-> cpu_ci);

  // R2: every peripheral acknowledge comes with cache-inhibit.
  a_r2_ci_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> cpu_ci);

  // R11: one response kind at a time, each a single cycle.
  a_r11_ack_berr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ack && cpu_berr));

  a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  // R7: the derived cycle must cover the PIO-0 minimum of 15 clocks at 25 MHz.
  initial begin
    a_r7_cycle_budget: assert (CYCLE_CLKS >= 15);
  end

endmodule

// File: tb/periph_bridge_test.sv
module periph_bridge_test;

  localparam logic [31:0] UART_A = 32'hFFF0_0000;
  localparam logic [31:0] CMD_A  = 32'hFFF0_0100;
  localparam logic [31:0] CTL_A  = 32'hFFF0_0200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_as;
  logic        cpu_rw;
  logic [31:0] cpu_addr;
  logic        cpu_ci, cpu_ack, cpu_berr;
  logic        uart_cs_n;
  logic [2:0]  uart_reg;
  logic        ide_cs0_n, ide_cs1_n;
  logic [2:0]  ide_da;
  logic        ide_rd_n, ide_wr_n;

  always #4 clk = ~clk;

  periph_bridge uut (
    .clk(clk), .rst_n(rst_n), .cpu_as(cpu_as), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .cpu_ci(cpu_ci), .cpu_ack(cpu_ack),
    .cpu_berr(cpu_berr), .uart_cs_n(uart_cs_n), .uart_reg(uart_reg),
    .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n), .ide_da(ide_da),
    .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // Pin monitor, sampled on falling edges.
  int cyc = 0;
  int cs_fall = 0, last_start = 0, prev_start = 0, last_end = 0, last_gap = 0;
  int cur_len = 0, last_len = 0, starts = 0;
  bit strb_prev = 0, cs_prev = 0, seen_rd = 0, seen_wr = 0;

  always @(negedge clk) begin
    bit strb, cs;
    cyc++;
    strb = !ide_rd_n || !ide_wr_n;
    cs   = !ide_cs0_n || !ide_cs1_n;
    if (cs && !cs_prev) cs_fall = cyc;
    if (strb && !strb_prev) begin
      prev_start = last_start;
      last_start = cyc;
      last_gap   = cyc - last_end;
      starts++;
      cur_len = 0;
    end
    if (strb) cur_len++;
    if (!strb && strb_prev) begin
      last_len = cur_len;
      last_end = cyc;
    end
    if (!ide_rd_n) seen_rd = 1;
    if (!ide_wr_n) seen_wr = 1;
    strb_prev = strb;
    cs_prev   = cs;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic begin_acc(input logic [31:0] a, input logic rw);
    @(negedge clk);
    cpu_addr = a;
    cpu_rw   = rw;
    cpu_as   = 1'b1;
    seen_rd  = 0;
    seen_wr  = 0;
    #1;
  endtask

  task automatic wait_resp(output int n);
    n = 0;
    while (!(cpu_ack || cpu_berr) && n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic end_acc();
    @(negedge clk);
    cpu_as = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cpu_as = 1'b0; cpu_rw = 1'b1; cpu_addr = '0;
    repeat (3) @(negedge clk);
    chk(ide_cs0_n && ide_cs1_n && ide_rd_n && ide_wr_n && uart_cs_n,
        "R1", "selects/strobes idle in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!cpu_ack && !cpu_berr && !cpu_ci, "R1", "ack/berr/ci after reset",
        {cpu_ack, cpu_berr, cpu_ci}, 0);
    chk(ide_cs0_n && ide_cs1_n && ide_rd_n && ide_wr_n, "R1",
        "ide idle after reset", 0, 0);
  endtask

  // Data-port read from an idle bridge; hold the request after the ack.
  task automatic t_ide_read();
    int n, s0;
    repeat (20) @(negedge clk);
    begin_acc(CMD_A, 1'b1);
    chk(cpu_ci, "R2", "ci with ide cmd address", cpu_ci, 1);
    s0 = starts;
    wait_resp(n);
    chk(cpu_ack && n == 8, "R6", "ide ack latency", n, 8);
    chk(!ide_cs0_n && ide_cs1_n, "R3", "cmd block uses cs0", ide_cs0_n, 0);
    chk(ide_da == 3'd0, "R3", "da for data port", ide_da, 0);
    chk(last_start - cs_fall == 2, "R4", "cs-to-strobe setup", last_start - cs_fall, 2);
    chk(last_len == 5, "R5", "strobe width", last_len, 5);
    chk(seen_rd && !seen_wr, "R5", "read strobe only", {seen_rd, seen_wr}, 2);
    chk(uart_cs_n, "R9", "uart idle during ide", uart_cs_n, 1);
    @(negedge clk); #1;
    chk(!cpu_ack, "R6", "ack lasts one cycle", cpu_ack, 0);
    begin
      int extra = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); #1;
        if (cpu_ack || cpu_berr) extra++;
      end
      chk(extra == 0 && starts == s0 + 1, "R11", "no repeat while as held",
          starts - s0, 1);
    end
    end_acc();
  endtask

  // Control-block write.
  task automatic t_ide_write_ctl();
    int n;
    repeat (20) @(negedge clk);
    begin_acc(CTL_A + 32'hC, 1'b0);
    chk(cpu_ci, "R2", "ci with ide ctl address", cpu_ci, 1);
    wait_resp(n);
    chk(cpu_ack && n == 8, "R6", "ctl write ack latency", n, 8);
    chk(ide_cs0_n && !ide_cs1_n, "R3", "ctl block uses cs1", ide_cs1_n, 0);
    chk(ide_da == 3'd6, "R3", "da for ctl offset 0xC", ide_da, 6);
    chk(seen_wr && !seen_rd, "R5", "write strobe only", {seen_rd, seen_wr}, 1);
    chk(last_len == 5, "R5", "write strobe width", last_len, 5);
    end_acc();
  endtask

  // Second read arrives while recovery is still counting.
  task automatic t_back_to_back();
    int n1, n2;
    repeat (20) @(negedge clk);
    begin_acc(CMD_A, 1'b1);
    wait_resp(n1);
    end_acc();
    begin_acc(CMD_A, 1'b1);
    chk(cpu_ci, "R2", "ci on early second read", cpu_ci, 1);
    wait_resp(n2);
    chk(cpu_ack, "R8", "second read acknowledged", cpu_ack, 1);
    chk(n2 > 8, "R8", "ack withheld during recovery", n2, 9);
    chk(last_start - prev_start == 15, "R7", "strobe spacing",
        last_start - prev_start, 15);
    chk(last_gap >= 7, "R7", "strobe high gap", last_gap, 7);
    end_acc();
  endtask

  task automatic t_uart();
    int n, s0;
    s0 = starts;
    begin_acc(UART_A + 32'h5, 1'b1);
    chk(cpu_ci, "R2", "ci with uart address", cpu_ci, 1);
    chk(!uart_cs_n && uart_reg == 3'd5, "R9", "uart select and offset", uart_reg, 5);
    wait_resp(n);
    chk(cpu_ack && n == 1, "R9", "uart ack latency", n, 1);
    @(negedge clk); #1;
    chk(!cpu_ack, "R11", "uart ack single", cpu_ack, 0);
    chk(starts == s0 && ide_cs0_n && ide_cs1_n, "R9", "no ide activity",
        starts - s0, 0);
    end_acc();
    chk(!cpu_ci, "R2", "ci low when idle", cpu_ci, 0);
  endtask

  task automatic t_unmapped(input logic [31:0] a);
    int n, s0;
    s0 = starts;
    begin_acc(a, 1'b1);
    chk(!cpu_ci, "R2", "ci low for unmapped", cpu_ci, 0);
    wait_resp(n);
    chk(cpu_berr && !cpu_ack && n == 32, "R10", "berr timeout", n, 32);
    chk(uart_cs_n && ide_cs0_n && ide_cs1_n && starts == s0, "R10",
        "no select on unmapped", starts - s0, 0);
    begin
      int extra = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); #1;
        if (cpu_berr || cpu_ack) extra++;
      end
      chk(extra == 0, "R11", "single berr while held", extra, 0);
    end
    end_acc();
  endtask

  initial begin
    t_reset();
    t_ide_read();
    t_ide_write_ctl();
    t_back_to_back();
    t_uart();
    t_unmapped(32'h0000_1000);
    t_unmapped(CMD_A + 32'h20);
    t_unmapped(CMD_A + 32'h1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule